// File: doc/BRIEF.md
# Divide-by-8/9 Dual-Modulus Prescaler

This block divides a fast input clock by 8 or by 9. A one-bit modulus-select input chooses the ratio. The divided clock drives a pulse-swallow counter. That counter sets the modulus-select line high for a programmed number of output periods and then low for the remaining periods of its frame.

The structure has two parts. The first is a synchronous divide-by-4/5 core of three flip-flops. NOR functions that pick the modulus sit in their data inputs. The second is a toggle flip-flop that advances once per core cycle, which halves the core rate.

The toggle phase gates the extra core count, so a divide-by-9 period is always one 5-cycle half plus one 4-cycle half. The modulus-select line is read at a single point in each output period. A change elsewhere in the period cannot shorten or stretch it.

Top module: `prescaler_div89`

## Requirements
- R1: While `rst` is high at a rising edge of `clk_in`, all state is cleared and `clk_out` is 1 after that edge.
- R2: With `mod_sel` held at 0, `clk_out` rises every 8 `clk_in` rising edges and stays low for 4 of them.
- R3: With `mod_sel` held at 1, `clk_out` rises every 9 `clk_in` rising edges and stays low for 5 of them.
- R4: The period length is set only by the value of `mod_sel` at the `clk_in` rising edge on which `clk_out` falls. A 1 there gives a low phase of 5 cycles (period 9). A 0 there gives 4 cycles (period 8). `mod_sel` values at any other edge have no effect.
- R5: After `rst` is released, the first rising edge of `clk_out` follows the 8th `clk_in` rising edge, or the 9th if `mod_sel` was 1 at the 4th edge.
- R6: The high phase of `clk_out` lasts exactly 4 `clk_in` cycles in every period, whatever the modulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous reset, active high |
| mod_sel | input | 1 | Modulus select: 0 divides by 8, 1 divides by 9 |
| clk_out | output | 1 | Divided clock, high for the first 4 cycles of each period |

## Verification
The assertions assume that `mod_sel` is stable around each `clk_in` rising edge. They also assume that `rst` is applied for at least one edge before the first output is judged, because the phase-length counter in the checker starts from the reset state. The stimulus changes `mod_sel` and `rst` only on falling edges of `clk_in`. It drives `mod_sel` with per-cycle patterns that place 1s and 0s both on and off the sampling edge, so the checker's captured sample is exercised against values that must be ignored.

// File: rtl/prescaler_div89.sv
module prescaler_div89 (
  input  logic clk_in,
  input  logic rst,
  input  logic mod_sel,
  output logic clk_out
);

  logic q1, q2, q3, tg;
  logic stretch, core_tick;

  assign stretch   = mod_sel & ~tg;
  assign core_tick = q2 & ~q1;

  always_ff @(posedge clk_in) begin
    if (rst) begin
      q1 <= 1'b0;
      q2 <= 1'b0;
      q3 <= 1'b0;
      tg <= 1'b0;
    end else begin
      q1 <= ~(q2 | q3);
      q2 <= q1;
      q3 <= ~(~q2 | ~stretch);
      tg <= tg ^ core_tick;
    end
  end

  assign clk_out = ~tg;

endmodule

module prescaler_div89_chk (
  input logic clk_in,
  input logic rst,
  input logic mod_sel,
  input logic clk_out
);

  logic       prev_out, mod_prev, mode_q, rst_q;
  logic [3:0] run;
  logic       fell_seen, rose_seen;

  assign fell_seen = prev_out & ~clk_out;
  assign rose_seen = ~prev_out & clk_out;

  always_ff @(posedge clk_in) begin
    rst_q <= rst;
    if (rst) begin
      prev_out <= 1'b1;
      run      <= 4'd0;
      mod_prev <= 1'b0;
      mode_q   <= 1'b0;
    end else begin
      prev_out <= clk_out;
      mod_prev <= mod_sel;
      if (clk_out != prev_out) run <= 4'd1;
      else if (run != 4'hf)    run <= run + 4'd1;
      if (fell_seen) mode_q <= mod_prev;
    end
  end

  assert_out_high_after_reset_R1: assert property (@(posedge clk_in) disable iff (rst)
    rst_q |-> clk_out);

  assert_low_phase_div8_R2: assert property (@(posedge clk_in) disable iff (rst)
    (rose_seen && !mode_q) |-> (run == 4'd4));

  assert_low_phase_div9_R3: assert property (@(posedge clk_in) disable iff (rst)
    (rose_seen && mode_q) |-> (run == 4'd5));

  assert_level_bound_R4: assert property (@(posedge clk_in) disable iff (rst)
    run <= 4'd5);

  assert_high_phase_R6: assert property (@(posedge clk_in) disable iff (rst)
    fell_seen |-> (run == 4'd4));

endmodule

bind prescaler_div89 prescaler_div89_chk u_chk (
  .clk_in (clk_in),
  .rst    (rst),
  .mod_sel(mod_sel),
  .clk_out(clk_out)
);

// File: tb/sim_prescaler_div89.sv
module sim_prescaler_div89;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mod_sel = 1'b0;
  logic clk_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string cur_tag = "R1";

  prescaler_div89 u0 (.clk_in(clk), .rst(rst), .mod_sel(mod_sel), .clk_out(clk_out));

  always #4 clk = ~clk;

  // behavioural reference: phase lengths in input cycles
  logic ref_out = 1'b1;
  int   cyc = 0;
  int   len = 4;

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      ref_out = 1'b1;
      cyc = 0;
      len = 4;
    end else begin
      cyc++;
      if (cyc == len) begin
        ref_out = !ref_out;
        cyc = 0;
        len = (!ref_out && mod_sel) ? 5 : 4;
      end
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(negedge clk) begin
    checks++;
    if (clk_out !== ref_out) begin
      errors++;
      $display("FAIL %s per-cycle compare: clk_out=%0b expected=%0b at cycle %0d",
               cur_tag, clk_out, ref_out, cycles);
    end
    if (cycles > 5000) begin
      errors++;
      $display("FAIL watchdog %s: cycles=%0d expected below 5000", cur_tag, cycles);
      finish_run();
    end
  end

  task automatic check_val(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Starts on the falling clock edge just after a clk_out rise or a reset release.
  // pat[j] is the mod_sel value presented to the (j+1)-th following rising edge.
  task automatic run_period(bit [8:0] pat, int exp, string tag);
    int  n = 0;
    int  hi = 0;
    logic prev;
    cur_tag = tag;
    prev = clk_out;
    if (clk_out) hi++;
    while (n < 20) begin
      mod_sel = (n < 9) ? pat[n] : 1'b0;
      @(negedge clk);
      n++;
      if (!prev && clk_out) break;
      if (clk_out) hi++;
      prev = clk_out;
    end
    check_val(tag, n, exp, "rising-edge spacing");
    check_val("R6", hi, 4, "high phase length");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cur_tag = "R1";
    check_val("R1", clk_out, 1, "clk_out during reset");
    rst = 1'b0;
    run_period(9'h000, 8, "R5");
    for (int i = 0; i < 3; i++) run_period(9'h000, 8, "R2");
    for (int i = 0; i < 3; i++) run_period(9'h1ff, 9, "R3");
    for (int i = 0; i < 4; i++)
      run_period((i % 2) ? 9'h1ff : 9'h000, (i % 2) ? 9 : 8, "R4");
    // values off the sampling edge are ignored
    run_period(9'h1f7, 8, "R4");
    run_period(9'h008, 9, "R4");
    run_period(9'h155, 8, "R4");
    run_period(9'h0aa, 9, "R4");
    // reset in mid-period while clk_out is low
    mod_sel = 1'b1;
    repeat (6) @(negedge clk);
    cur_tag = "R1";
    check_val("R1", clk_out, 0, "clk_out low before mid-period reset");
    rst = 1'b1;
    @(negedge clk);
    check_val("R1", clk_out, 1, "clk_out after mid-period reset");
    rst = 1'b0;
    run_period(9'h1ff, 9, "R5");
    run_period(9'h1ff, 9, "R3");
    finish_run();
  end

endmodule